// File: doc/BRIEF.md
# Memory Subregion Access Filter

This block guards a set of small on-chip memories. For each memory it holds two
independently configured windows, called subregion A and subregion B. Each window
has an enable, a sticky lock, a required compartment identifier (CID), and flags
that demand secure and privileged accesses. Its extent is a start offset and a
length, both counted in 8-byte granules. Software programs the windows through a
simple word-wide register port.

The access side takes a memory index, a byte offset inside that memory, and the
requester's CID, secure flag and privilege flag. One cycle later it returns grant
or deny. An access that falls in an enabled window must satisfy every window it
falls in. An access that falls in no enabled window is granted. The first
`FULL_MEMS` memories have no address word. Their windows always span the whole
memory, so only their attributes can be programmed.

Top module: `subregion_filter`

## Requirements
- R1: After reset every window is disabled and unlocked, all configuration words read 0, and `chk_done` and `chk_grant` are 0.
- R2: Register map: window s of memory m has its configuration word at byte offset 16*m + 8*s and its address word at 16*m + 8*s + 4. Configuration word fields: bit 0 enable, bit 1 lock, bits 6:4 CID, bit 8 secure-only, bit 9 privileged-only. Address word fields: start granule in bits 10:0, length in granules in bits 27:16. Unused bits read 0. `reg_rdata` shows the word addressed in the previous cycle.
- R3: `chk_done` is 1 exactly one cycle after `chk_valid` is 1, and 0 otherwise. `chk_grant` is 0 whenever `chk_done` is 0.
- R4: An access that falls in no enabled window of its memory is granted.
- R5: The granule of an access is its byte offset shifted right by 3. A window covers granules start through start+length-1, and a length of 0 covers nothing.
- R6: An access inside an enabled window whose CID differs from the window's CID is denied.
- R7: An access inside an enabled secure-only window is denied when its secure flag is 0.
- R8: An access inside an enabled privileged-only window is denied when its privilege flag is 0.
- R9: When both windows are enabled and both cover an access, the access is granted only if both windows allow it.
- R10: The write that sets the lock bit is accepted. After it, writes to that window's configuration and address words are ignored until reset.
- R11: In the first `FULL_MEMS` memories the windows cover every offset. Their address words read 0 and ignore writes.
- R12: A disabled window has no effect, even when it covers the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset (low two bits ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's `reg_addr` |
| chk_valid | input | 1 | Access check request |
| chk_mem | input | MEM_W | Memory index of the access |
| chk_addr | input | ADDR_W | Byte offset inside the memory |
| chk_cid | input | 3 | Requester compartment identifier |
| chk_sec | input | 1 | Requester is secure |
| chk_priv | input | 1 | Requester is privileged |
| chk_done | output | 1 | Check result valid |
| chk_grant | output | 1 | Access granted (valid with `chk_done`) |

## Verification
Checks are made on a partially sized memory around a three-granule window: at
the granule just below it, at its first and last bytes, and just past its end.
These tell a correct range compare from an off-by-one compare or from one that
ignores the shift by 3. The requester's CID, secure flag and privilege flag are
each varied on their own, which isolates each term of the allow rule. Two
overlapping windows with different CIDs tell "all hit windows must allow" from
"any window allows". Further checks cover:
- a disabled window;
- a zero-length window;
- writes after lock;
- a whole-range memory at its highest offset.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int CID_W     = 3;
  localparam int START_W   = 11;
  localparam int LEN_W     = 12;
  localparam int GRAN_LOG2 = 3;
  localparam int WORD_W    = 32;
  localparam int SUM_W     = ((LEN_W > START_W) ? LEN_W : START_W) + 1;

  // configuration word bit positions
  localparam int B_EN     = 0;
  localparam int B_LOCK   = 1;
  localparam int B_CID    = 4;
  localparam int B_SEC    = 8;
  localparam int B_PRIV   = 9;
  // address word bit positions
  localparam int B_START  = 0;
  localparam int B_LEN    = 16;

  typedef struct packed {
    logic               en;
    logic               lock;
    logic [CID_W-1:0]   cid;
    logic               sec;
    logic               priv;
    logic [START_W-1:0] start;
    logic [LEN_W-1:0]   len;
  } win_attr_t;

  localparam int ATTR_W = $bits(win_attr_t);

  function automatic logic [WORD_W-1:0] cfg_word(input win_attr_t a);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_EN]                 = a.en;
    w[B_LOCK]               = a.lock;
    w[B_CID +: CID_W]       = a.cid;
    w[B_SEC]                = a.sec;
    w[B_PRIV]               = a.priv;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] addr_word(input win_attr_t a);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_START +: START_W] = a.start;
    w[B_LEN +: LEN_W]     = a.len;
    return w;
  endfunction
endpackage

// File: rtl/srf_window_reg.sv
module srf_window_reg
  import srf_pkg::*;
#(
  parameter bit WHOLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              addr_we,
  input  logic [WORD_W-1:0] wdata,
  output win_attr_t         attr
);
  win_attr_t q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q.en    <= 1'b0;
      q.lock  <= 1'b0;
      q.cid   <= '0;
      q.sec   <= 1'b0;
      q.priv  <= 1'b0;
      q.start <= '0;
      q.len   <= WHOLE ? {LEN_W{1'b1}} : '0;
    end else if (!q.lock) begin
      if (cfg_we) begin
        q.en   <= wdata[B_EN];
        q.lock <= wdata[B_LOCK];
        q.cid  <= wdata[B_CID +: CID_W];
        q.sec  <= wdata[B_SEC];
        q.priv <= wdata[B_PRIV];
      end
      if (addr_we && !WHOLE) begin
        q.start <= wdata[B_START +: START_W];
        q.len   <= wdata[B_LEN +: LEN_W];
      end
    end
  end

  assign attr = q;
endmodule

// File: rtl/srf_window_match.sv
module srf_window_match
  import srf_pkg::*;
(
  input  win_attr_t          attr,
  input  logic [START_W-1:0] gran,
  input  logic [CID_W-1:0]   cid,
  input  logic               sec,
  input  logic               priv,
  output logic               hit,
  output logic               allow
);
  logic [SUM_W-1:0] lo;
  logic [SUM_W-1:0] hi;
  logic [SUM_W-1:0] g;

  always_comb begin
    lo    = SUM_W'(attr.start);
    hi    = SUM_W'(attr.start) + SUM_W'(attr.len);
    g     = SUM_W'(gran);
    hit   = attr.en && (g >= lo) && (g < hi);
    allow = (attr.cid == cid) && (sec || !attr.sec) && (priv || !attr.priv);
  end
endmodule

// File: rtl/srf_readback.sv
module srf_readback
  import srf_pkg::*;
#(
  parameter int NUM_MEMS  = 4,
  parameter int FULL_MEMS = 2,
  parameter int MEM_W     = $clog2(NUM_MEMS),
  parameter int REG_AW    = MEM_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] rd_addr,
  input  win_attr_t         attrs [NUM_MEMS*2],
  output logic [WORD_W-1:0] rdata
);
  logic [MEM_W-1:0] mem;
  logic             sub;
  logic             is_addr;
  logic [MEM_W:0]   idx;
  win_attr_t        a;

  always_comb begin
    mem     = rd_addr[REG_AW-1:4];
    sub     = rd_addr[3];
    is_addr = rd_addr[2];
    idx     = {mem, sub};
    a       = attrs[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (is_addr) begin
      rdata <= (int'(mem) < FULL_MEMS) ? '0 : addr_word(a);
    end else begin
      rdata <= cfg_word(a);
    end
  end
endmodule

// File: rtl/subregion_filter.sv
module subregion_filter
  import srf_pkg::*;
#(
  parameter int NUM_MEMS  = 4,   // power of two
  parameter int FULL_MEMS = 2,
  parameter int MEM_W     = $clog2(NUM_MEMS),
  parameter int REG_AW    = MEM_W + 4,
  parameter int ADDR_W    = START_W + GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              chk_valid,
  input  logic [MEM_W-1:0]  chk_mem,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [2:0]        chk_cid,
  input  logic              chk_sec,
  input  logic              chk_priv,
  output logic              chk_done,
  output logic              chk_grant
);
  localparam int NWIN = NUM_MEMS * 2;

  win_attr_t               attrs [NWIN];
  logic [NWIN-1:0]         lock_vec;
  logic [NWIN-1:0]         en_vec;
  logic [NWIN*ATTR_W-1:0]  attr_flat;

  logic [MEM_W-1:0] wr_mem;
  logic             wr_sub;
  logic             wr_is_addr;

  assign wr_mem     = reg_addr[REG_AW-1:4];
  assign wr_sub     = reg_addr[3];
  assign wr_is_addr = reg_addr[2];

  for (genvar m = 0; m < NUM_MEMS; m++) begin : g_mem
    for (genvar s = 0; s < 2; s++) begin : g_win
      localparam int IDX = m * 2 + s;
      logic sel;
      assign sel = reg_we && (int'(wr_mem) == m) && (wr_sub == s[0]);

      srf_window_reg #(.WHOLE(m < FULL_MEMS)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .cfg_we (sel && !wr_is_addr),
        .addr_we(sel && wr_is_addr),
        .wdata  (reg_wdata),
        .attr   (attrs[IDX])
      );

      assign lock_vec[IDX] = attrs[IDX].lock;
      assign en_vec[IDX]   = attrs[IDX].en;
      assign attr_flat[IDX*ATTR_W +: ATTR_W] = attrs[IDX];
    end
  end

  srf_readback #(
    .NUM_MEMS (NUM_MEMS),
    .FULL_MEMS(FULL_MEMS),
    .MEM_W    (MEM_W),
    .REG_AW   (REG_AW)
  ) u_rb (
    .clk    (clk),
    .rst    (rst),
    .rd_addr(reg_addr),
    .attrs  (attrs),
    .rdata  (reg_rdata)
  );

  // access check path
  logic [START_W-1:0] gran;
  logic [1:0]         hit;
  logic [1:0]         allow;
  logic               grant_c;

  assign gran = chk_addr[ADDR_W-1:GRAN_LOG2];

  for (genvar s = 0; s < 2; s++) begin : g_cmp
    srf_window_match u_match (
      .attr (attrs[{chk_mem, s[0]}]),
      .gran (gran),
      .cid  (chk_cid),
      .sec  (chk_sec),
      .priv (chk_priv),
      .hit  (hit[s]),
      .allow(allow[s])
    );
  end

  assign grant_c = &(~hit | allow);

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_done  <= 1'b0;
      chk_grant <= 1'b0;
    end else begin
      chk_done  <= chk_valid;
      chk_grant <= chk_valid && grant_c;
    end
  end
endmodule

// File: rtl/srf_checker.sv
module srf_checker
  import srf_pkg::*;
#(
  parameter int NUM_MEMS = 4,
  parameter int MEM_W    = 2
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            chk_valid,
  input logic [MEM_W-1:0]                chk_mem,
  input logic                            chk_done,
  input logic                            chk_grant,
  input logic [NUM_MEMS*2-1:0]           lock_vec,
  input logic [NUM_MEMS*2-1:0]           en_vec,
  input logic [NUM_MEMS*2*ATTR_W-1:0]    attr_flat
);
  a_r3_done_after_valid: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_done);

  a_r3_no_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !chk_done);

  a_r3_grant_with_done: assert property (@(posedge clk) disable iff (rst)
    chk_grant |-> chk_done);

  a_r4_default_grant: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && !en_vec[{chk_mem, 1'b0}] && !en_vec[{chk_mem, 1'b1}]) |=> chk_grant);

  for (genvar i = 0; i < NUM_MEMS * 2; i++) begin : g_lock
    a_r10_locked_frozen: assert property (@(posedge clk) disable iff (rst)
      lock_vec[i] |=> $stable(attr_flat[i*ATTR_W +: ATTR_W]));
  end
endmodule

bind subregion_filter srf_checker #(
  .NUM_MEMS(NUM_MEMS),
  .MEM_W   (MEM_W)
) u_srf_checker (
  .clk      (clk),
  .rst      (rst),
  .chk_valid(chk_valid),
  .chk_mem  (chk_mem),
  .chk_done (chk_done),
  .chk_grant(chk_grant),
  .lock_vec (lock_vec),
  .en_vec   (en_vec),
  .attr_flat(attr_flat)
);

// File: tb/subregion_filter_bench.sv
module subregion_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        chk_valid = 1'b0;
  logic [1:0]  chk_mem = '0;
  logic [13:0] chk_addr = '0;
  logic [2:0]  chk_cid = '0;
  logic        chk_sec = 1'b0;
  logic        chk_priv = 1'b0;
  logic        chk_done;
  logic        chk_grant;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  subregion_filter u_subregion_filter (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chk_valid(chk_valid),
    .chk_mem(chk_mem), .chk_addr(chk_addr), .chk_cid(chk_cid),
    .chk_sec(chk_sec), .chk_priv(chk_priv), .chk_done(chk_done),
    .chk_grant(chk_grant)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] cfg_off(input int m, input int s);
    return 6'(16 * m + 8 * s);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic access(input string tag, input int m, input logic [13:0] a,
                        input logic [2:0] cid, input logic s, input logic p,
                        input logic exp_grant);
    @(negedge clk);
    chk_valid = 1'b1; chk_mem = 2'(m); chk_addr = a;
    chk_cid = cid; chk_sec = s; chk_priv = p;
    @(negedge clk);
    chk_valid = 1'b0;
    check(tag, {30'd0, chk_done, chk_grant}, {30'd0, 1'b1, exp_grant});
  endtask

  task automatic t_reset;
    check("R1 done after reset", {31'd0, chk_done}, 32'd0);
    check("R1 grant after reset", {31'd0, chk_grant}, 32'd0);
    rd_check("R1 cfg word after reset", cfg_off(2, 0), 32'h0);
  endtask

  task automatic t_default_and_idle;
    access("R4 nothing enabled", 2, 14'h100, 3'd6, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check("R3 done drops when idle", {31'd0, chk_done}, 32'd0);
  endtask

  task automatic t_range_cid;
    wr(cfg_off(2, 0) + 6'd4, 32'h0003_0004);   // start 4, length 3
    wr(cfg_off(2, 0), 32'h0000_0011);          // enable, cid 1
    rd_check("R2 addr word readback", cfg_off(2, 0) + 6'd4, 32'h0003_0004);
    rd_check("R2 cfg word readback", cfg_off(2, 0), 32'h0000_0011);
    access("R5 granule below window", 2, 14'h01F, 3'd2, 1'b0, 1'b0, 1'b1);
    access("R6 first byte wrong cid", 2, 14'h020, 3'd2, 1'b0, 1'b0, 1'b0);
    access("R5 last byte wrong cid", 2, 14'h037, 3'd2, 1'b0, 1'b0, 1'b0);
    access("R5 past end", 2, 14'h038, 3'd2, 1'b0, 1'b0, 1'b1);
    access("R6 matching cid", 2, 14'h020, 3'd1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_sec_priv;
    wr(cfg_off(2, 0), 32'h0000_0311);          // + secure-only, privileged-only
    access("R7 nonsecure denied", 2, 14'h028, 3'd1, 1'b0, 1'b1, 1'b0);
    access("R8 unprivileged denied", 2, 14'h028, 3'd1, 1'b1, 1'b0, 1'b0);
    access("R7 R8 secure privileged granted", 2, 14'h028, 3'd1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_overlap;
    wr(cfg_off(2, 1) + 6'd4, 32'h000A_0005);   // start 5, length 10
    wr(cfg_off(2, 1), 32'h0000_0021);          // enable, cid 2
    access("R9 overlap cid of A", 2, 14'h028, 3'd1, 1'b1, 1'b1, 1'b0);
    access("R9 overlap cid of B", 2, 14'h028, 3'd2, 1'b1, 1'b1, 1'b0);
    access("R9 only B covers", 2, 14'h050, 3'd2, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_disabled_zero;
    wr(cfg_off(2, 1), 32'h0000_0020);          // B disabled
    access("R12 disabled window ignored", 2, 14'h050, 3'd1, 1'b0, 1'b0, 1'b1);
    access("R12 overlap with B disabled", 2, 14'h028, 3'd1, 1'b1, 1'b1, 1'b1);
    wr(cfg_off(2, 1) + 6'd4, 32'h0000_0005);   // length 0
    wr(cfg_off(2, 1), 32'h0000_0021);
    access("R5 zero length covers nothing", 2, 14'h028, 3'd1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_lock;
    wr(cfg_off(3, 0) + 6'd4, 32'h0002_0000);   // start 0, length 2
    wr(cfg_off(3, 0), 32'h0000_0033);          // enable, lock, cid 3
    wr(cfg_off(3, 0), 32'h0000_0000);
    wr(cfg_off(3, 0) + 6'd4, 32'h0050_0064);
    rd_check("R10 cfg kept after lock", cfg_off(3, 0), 32'h0000_0033);
    rd_check("R10 addr kept after lock", cfg_off(3, 0) + 6'd4, 32'h0002_0000);
    access("R10 locked window still filters", 3, 14'h008, 3'd0, 1'b1, 1'b1, 1'b0);
    access("R10 outside locked window", 3, 14'h010, 3'd0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_whole;
    wr(cfg_off(0, 0), 32'h0000_0051);          // enable, cid 5
    wr(cfg_off(0, 0) + 6'd4, 32'h0001_0001);
    rd_check("R11 address word reads 0", cfg_off(0, 0) + 6'd4, 32'h0);
    access("R11 top offset wrong cid", 0, 14'h3FF8, 3'd4, 1'b0, 1'b0, 1'b0);
    access("R11 offset 0 wrong cid", 0, 14'h0000, 3'd4, 1'b0, 1'b0, 1'b0);
    access("R11 top offset right cid", 0, 14'h3FF8, 3'd5, 1'b0, 1'b0, 1'b1);
    access("R4 other memory unaffected", 1, 14'h3FF8, 3'd4, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_fields;
    wr(cfg_off(1, 1), 32'hFFFF_FFFD);
    rd_check("R2 cfg unused bits read 0", cfg_off(1, 1), 32'h0000_0371);
    wr(cfg_off(3, 1) + 6'd4, 32'hFFFF_FFFF);
    rd_check("R2 addr unused bits read 0", cfg_off(3, 1) + 6'd4, 32'h0FFF_07FF);
  endtask

  task automatic t_lock_reset;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_check("R10 reset clears lock", cfg_off(3, 0), 32'h0);
    wr(cfg_off(3, 0), 32'h0000_0001);
    rd_check("R10 writable after reset", cfg_off(3, 0), 32'h0000_0001);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default_and_idle();
    t_range_cid();
    t_sec_priv();
    t_overlap();
    t_disabled_zero();
    t_lock();
    t_whole();
    t_fields();
    t_lock_reset();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule